// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block is a 32-bit integer datapath for signal-processing code that must not wrap around on overflow. One operation code selects one of these functions: a signed or unsigned add or subtract that clamps at the range limits, a wrapping signed add that only reports overflow, or a clamp of a value to a chosen bit width. The clamp works either on the whole word or separately on each 16-bit half, and comes in signed and unsigned forms. The result is a pure combinational function of the operation code, the two operands and the width input.

Any operation that clamps its result, plus the wrapping add when it overflows, raises a single sticky flag. The flag is shared by all of these operations. It updates on a clock edge only when the operation strobe is high. No operation ever lowers it. Only the dedicated clear input lowers it, and that clear wins over a set in the same cycle. Software-visible saturation tracking then costs one register bit.

Top module: `sat_alu`

## Requirements
- R1: Signed add (op 0): when both operands have the same sign and the 32-bit sum has the other sign, the result is 0x7FFFFFFF for a non-negative first operand and 0x80000000 for a negative one, and saturation is reported; otherwise the result is the sum.
- R2: Signed subtract (op 1): when the operands differ in sign and the difference's sign differs from the first operand, the result clamps to 0x7FFFFFFF or 0x80000000 by the first operand's sign and saturation is reported; otherwise the result is a minus b.
- R3: Unsigned add (op 2) gives 0xFFFFFFFF on a carry out, and unsigned subtract (op 3) gives 0 on a borrow; both report saturation in that case and give the plain result otherwise.
- R4: Wrapping add (op 4) always returns the 32-bit sum modulo 2^32 and reports saturation exactly when a signed overflow occurs.
- R5: Signed word clamp (op 5) with n = sat_n: when a arithmetically shifted right by n is above 0, the result is 2^n-1; when it is below -1, the result is the bitwise inverse of 2^n-1; otherwise a passes unchanged. Either clamp reports saturation.
- R6: Unsigned word clamp (op 6) with n = sat_n gives 0 for a negative a and 2^n-1 for a above 2^n-1, reporting saturation in both cases; otherwise a passes.
- R7: Halfword clamps (op 7 signed, op 8 unsigned) treat a[15:0] and a[31:16] as separate signed 16-bit values, apply the R5/R6 rule to each with n = sat_n[3:0], and place the results in result[15:0] and result[31:16]; saturation of either half is reported.
- R8: The sticky flag goes high on the rising clock edge where op_valid is high and the selected operation reports saturation, stays high through later operations, and never rises while op_valid is low.
- R9: flag_clr high at a rising edge leaves the flag low after that edge, even if a saturating operation is strobed in the same cycle.
- R10: Operation codes 9 to 15 pass operand a to the result unchanged and never set the flag.
- R11: While rst_n is low the flag is 0.
- R12: result follows its inputs in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: let this cycle's saturation update the flag |
| op_sel | input | 4 | Operation code (see R1 to R10) |
| opnd_a | input | 32 | First operand / value to clamp |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_n | input | 5 | Clamp width n |
| flag_clr | input | 1 | Clears the sticky flag, wins over a set |
| result | output | 32 | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The result is due in the same cycle as its operands, so the bench drives inputs just after a falling edge and reads result one nanosecond later, before any rising edge. The flag is due one rising edge after the strobe. Each case first clears the flag for one cycle, then holds the strobe across exactly one rising edge and samples the flag at the next falling edge. A case therefore observes only its own contribution, except in the sticky and clear-priority scenarios, which deliberately chain cycles.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_UADD   = 4'd2,
    OP_USUB   = 4'd3,
    OP_WADD   = 4'd4,
    OP_SSAT_W = 4'd5,
    OP_USAT_W = 4'd6,
    OP_SSAT_H = 4'd7,
    OP_USAT_H = 4'd8
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res,
  output logic            hit
);
  localparam int MSB = W - 1;

  logic [W:0]   sum_x;
  logic [W:0]   dif_x;
  logic         s_add_ovf;
  logic         s_sub_ovf;
  logic [W-1:0] s_limit;

  always_comb begin
    sum_x     = {1'b0, a} + {1'b0, b};
    dif_x     = {1'b0, a} - {1'b0, b};
    s_add_ovf = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
    s_sub_ovf = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
    s_limit   = a[MSB] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  end

  always_comb begin
    res = sum_x[W-1:0];
    hit = 1'b0;
    case (sat_op_e'(op))
      OP_SADD: begin
        hit = s_add_ovf;
        res = s_add_ovf ? s_limit : sum_x[W-1:0];
      end
      OP_SSUB: begin
        hit = s_sub_ovf;
        res = s_sub_ovf ? s_limit : dif_x[W-1:0];
      end
      OP_UADD: begin
        hit = sum_x[W];
        res = sum_x[W] ? {W{1'b1}} : sum_x[W-1:0];
      end
      OP_USUB: begin
        hit = dif_x[W];
        res = dif_x[W] ? {W{1'b0}} : dif_x[W-1:0];
      end
      OP_WADD: begin
        hit = s_add_ovf;
        res = sum_x[W-1:0];
      end
      default: begin
        hit = 1'b0;
        res = sum_x[W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 32,
  parameter int NW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [NW-1:0] n,
  input  logic          is_signed,
  output logic [W-1:0]  res,
  output logic          hit
);
  logic [W-1:0]        mask;
  logic signed [W-1:0] top;

  always_comb begin
    mask = ({{(W-1){1'b0}}, 1'b1} << n) - {{(W-1){1'b0}}, 1'b1};
    top  = $signed(val) >>> n;
    res  = val;
    hit  = 1'b0;
    if (is_signed) begin
      if (top > 0) begin
        res = mask;
        hit = 1'b1;
      end else if (top < -1) begin
        res = ~mask;
        hit = 1'b1;
      end
    end else begin
      if (val[W-1]) begin
        res = '0;
        hit = 1'b1;
      end else if (val > mask) begin
        res = mask;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_sticky.sv
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr) begin
      flag_d = 1'b0;
    end else if (upd_en && hit) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag_q); // R9
  AST_RISE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(upd_en)); // R8
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SAT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SAT_W-1:0]  sat_n,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag
);
  localparam int HALF_W = DATA_W / 2;
  localparam int HN_W   = $clog2(HALF_W);
  localparam int N_HALF = 2;

  logic [DATA_W-1:0] as_res;
  logic              as_hit;
  logic [DATA_W-1:0] cw_res;
  logic              cw_hit;
  logic [HALF_W-1:0] ch_res [N_HALF];
  logic [N_HALF-1:0] ch_hit;
  logic              word_signed;
  logic              half_signed;
  logic              any_hit;

  assign word_signed = (op_sel == OP_SSAT_W);
  assign half_signed = (op_sel == OP_SSAT_H);

  sat_addsub #(.W(DATA_W)) u_addsub (
    .op  (op_sel),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (as_res),
    .hit (as_hit)
  );

  sat_clamp #(.W(DATA_W), .NW(SAT_W)) u_clamp_word (
    .val       (opnd_a),
    .n         (sat_n),
    .is_signed (word_signed),
    .res       (cw_res),
    .hit       (cw_hit)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    sat_clamp #(.W(HALF_W), .NW(HN_W)) u_clamp_half (
      .val       (opnd_a[h*HALF_W +: HALF_W]),
      .n         (sat_n[HN_W-1:0]),
      .is_signed (half_signed),
      .res       (ch_res[h]),
      .hit       (ch_hit[h])
    );
  end

  always_comb begin
    result  = opnd_a;
    any_hit = 1'b0;
    case (sat_op_e'(op_sel))
      OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_WADD: begin
        result  = as_res;
        any_hit = as_hit;
      end
      OP_SSAT_W, OP_USAT_W: begin
        result  = cw_res;
        any_hit = cw_hit;
      end
      OP_SSAT_H, OP_USAT_H: begin
        result  = {ch_res[1], ch_res[0]};
        any_hit = |ch_hit;
      end
      default: begin
        result  = opnd_a;
        any_hit = 1'b0;
      end
    endcase
  end

  sat_sticky u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (op_valid),
    .hit    (any_hit),
    .clr    (flag_clr),
    .flag   (sat_flag)
  );

  AST_UADD_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_UADD) |-> (result >= opnd_a)); // R3
  AST_USUB_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_USUB) |-> (result <= opnd_a)); // R3
  AST_USAT_WORD_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_USAT_W) |-> !result[DATA_W-1]); // R6
  AST_USAT_HALF_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == OP_USAT_H) |-> (!result[DATA_W-1] && !result[HALF_W-1])); // R7
  AST_SPARE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_USAT_H) |-> (result == opnd_a)); // R10
  AST_SPARE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_USAT_H && !sat_flag) |=> !sat_flag); // R10
endmodule

// File: tb/sat_alu_bench.sv
`timescale 1ns/1ps
module sat_alu_bench;
  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_sel;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [4:0]  sat_n;
  logic        flag_clr;
  logic [31:0] result;
  logic        sat_flag;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  sat_alu u_sat_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_n(sat_n), .flag_clr(flag_clr),
    .result(result), .sat_flag(sat_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Clear flag, apply one strobed op, check result same cycle, flag one edge later.
  task automatic run_case(input string req, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] n,
                          input logic [31:0] exp_res, input logic exp_flag);
    @(negedge clk);
    flag_clr = 1'b1; op_valid = 1'b0;
    @(negedge clk);
    flag_clr = 1'b0;
    op_sel = op; opnd_a = a; opnd_b = b; sat_n = n; op_valid = 1'b1;
    #1;
    chk({req, " result"}, result, exp_res);
    @(negedge clk);
    op_valid = 1'b0;
    chk({req, " flag"}, {31'd0, sat_flag}, {31'd0, exp_flag});
  endtask

  task automatic t_reset;
    chk("R11 flag in reset", {31'd0, sat_flag}, 32'd0);
  endtask

  task automatic t_signed_add;
    run_case("R1 pos ovf", 4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1);
    run_case("R1 neg ovf", 4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1);
    run_case("R1 plain",   4'd0, 32'd5, 32'd7, 5'd0, 32'd12, 1'b0);
    run_case("R1 mixed",   4'd0, 32'h7FFFFFFF, 32'h80000000, 5'd0, 32'hFFFFFFFF, 1'b0);
  endtask

  task automatic t_signed_sub;
    run_case("R2 neg ovf", 4'd1, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1);
    run_case("R2 pos ovf", 4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1);
    run_case("R2 plain",   4'd1, 32'd10, 32'd3, 5'd0, 32'd7, 1'b0);
  endtask

  task automatic t_unsigned;
    run_case("R3 uadd carry",  4'd2, 32'hFFFFFFF0, 32'h20, 5'd0, 32'hFFFFFFFF, 1'b1);
    run_case("R3 uadd plain",  4'd2, 32'd1, 32'd2, 5'd0, 32'd3, 1'b0);
    run_case("R3 usub borrow", 4'd3, 32'd3, 32'd5, 5'd0, 32'd0, 1'b1);
    run_case("R3 usub plain",  4'd3, 32'd5, 32'd3, 5'd0, 32'd2, 1'b0);
    run_case("R3 usub zero",   4'd3, 32'd0, 32'd0, 5'd0, 32'd0, 1'b0);
  endtask

  task automatic t_wrap_add;
    run_case("R4 wrap ovf",   4'd4, 32'h7FFFFFFF, 32'h1, 5'd0, 32'h80000000, 1'b1);
    run_case("R4 wrap plain", 4'd4, 32'd2, 32'd3, 5'd0, 32'd5, 1'b0);
  endtask

  task automatic t_ssat_word;
    run_case("R5 high",     4'd5, 32'd200, 32'd0, 5'd7, 32'd127, 1'b1);
    run_case("R5 low",      4'd5, 32'hFFFFFF38, 32'd0, 5'd7, 32'hFFFFFF80, 1'b1);
    run_case("R5 at min",   4'd5, 32'hFFFFFF80, 32'd0, 5'd7, 32'hFFFFFF80, 1'b0);
    run_case("R5 at max",   4'd5, 32'd127, 32'd0, 5'd7, 32'd127, 1'b0);
    run_case("R5 n31",      4'd5, 32'h80000000, 32'd0, 5'd31, 32'h80000000, 1'b0);
    run_case("R5 n0 pos",   4'd5, 32'd5, 32'd0, 5'd0, 32'd0, 1'b1);
    run_case("R5 n0 minus1",4'd5, 32'hFFFFFFFF, 32'd0, 5'd0, 32'hFFFFFFFF, 1'b0);
  endtask

  task automatic t_usat_word;
    run_case("R6 high",   4'd6, 32'd300, 32'd0, 5'd8, 32'd255, 1'b1);
    run_case("R6 neg",    4'd6, 32'hFFFFFFFF, 32'd0, 5'd8, 32'd0, 1'b1);
    run_case("R6 at max", 4'd6, 32'd255, 32'd0, 5'd8, 32'd255, 1'b0);
    run_case("R6 n31",    4'd6, 32'h7FFFFFFF, 32'd0, 5'd31, 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_halves;
    run_case("R7 both sat",  4'd7, 32'h0100FF00, 32'd0, 5'd7, 32'h007FFF80, 1'b1);
    run_case("R7 none sat",  4'd7, 32'h0010FFF0, 32'd0, 5'd7, 32'h0010FFF0, 1'b0);
    run_case("R7 upper sat", 4'd7, 32'h01000005, 32'd0, 5'd7, 32'h007F0005, 1'b1);
    run_case("R7 usat",      4'd8, 32'hFFFF0020, 32'd0, 5'd4, 32'h0000000F, 1'b1);
    run_case("R7 n bit4",    4'd8, 32'h00030009, 32'd0, 5'd20, 32'h00030009, 1'b0);
  endtask

  task automatic t_spare;
    run_case("R10 code 9",  4'd9,  32'h12345678, 32'hFFFFFFFF, 5'd0, 32'h12345678, 1'b0);
    run_case("R10 code 15", 4'd15, 32'h80000000, 32'h80000000, 5'd31, 32'h80000000, 1'b0);
  endtask

  task automatic t_sticky;
    // Saturating op without strobe must not set flag.
    @(negedge clk);
    flag_clr = 1'b1; op_valid = 1'b0;
    @(negedge clk);
    flag_clr = 1'b0; op_sel = 4'd2; opnd_a = 32'hFFFFFFFF; opnd_b = 32'd1;
    @(negedge clk);
    chk("R8 no strobe no set", {31'd0, sat_flag}, 32'd0);
    // Set, then non-saturating strobed op keeps it.
    op_valid = 1'b1;
    @(negedge clk);
    chk("R8 set", {31'd0, sat_flag}, 32'd1);
    opnd_a = 32'd1; opnd_b = 32'd1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R8 sticky after clean op", {31'd0, sat_flag}, 32'd1);
    @(negedge clk);
    chk("R8 sticky idle", {31'd0, sat_flag}, 32'd1);
  endtask

  task automatic t_clear_priority;
    @(negedge clk);
    op_sel = 4'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'd1; op_valid = 1'b1; flag_clr = 1'b0;
    @(negedge clk);
    chk("R9 preset", {31'd0, sat_flag}, 32'd1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; op_valid = 1'b0;
    chk("R9 clear beats set", {31'd0, sat_flag}, 32'd0);
  endtask

  task automatic t_comb;
    @(negedge clk);
    op_sel = 4'd4; opnd_a = 32'd100; opnd_b = 32'd23;
    #1 chk("R12 same cycle a", result, 32'd123);
    opnd_b = 32'd900;
    #1 chk("R12 same cycle b", result, 32'd1000);
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_sel = 4'd0; opnd_a = '0; opnd_b = '0;
    sat_n = '0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_signed_add();
    t_signed_sub();
    t_unsigned();
    t_wrap_add();
    t_ssat_word();
    t_usat_word();
    t_halves();
    t_spare();
    t_sticky();
    t_clear_priority();
    t_comb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule